// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line programmable interrupt controller. A host writes and reads it through a synchronous strobe interface with one address bit. At address 0 the host issues a start-of-setup command, mode commands or end-of-interrupt commands. At address 1 the host supplies the setup words that follow a start command, and afterwards it loads the mask. The block holds the mask, the vector base, the mode flags, the rotating priority offset and the in-service register. It clears in-service lines on end-of-interrupt commands.

The request register lives in the capture logic and arrives on `req_in`. A poll read picks the winning line and acknowledges it. The block then raises `poll_ack` with `ack_line`, so that the capture logic can drop an edge request. A start command raises `init_clr` so that the capture logic can clear its request and previous-level state.

The setup sequencer has four named states. ST_MASK is idle: address-1 writes load the mask. ST_BASE takes the vector base. ST_CASCADE takes the cascade word. ST_MODE takes the mode word. A start command moves any state to ST_BASE. The transitions on an address-1 write are:
- ST_BASE goes to ST_CASCADE when cascaded, to ST_MODE when single and a mode word is needed, and to ST_MASK otherwise.
- ST_CASCADE goes to ST_MODE when a mode word is needed, and to ST_MASK otherwise.
- ST_MODE goes to ST_MASK.
- ST_MASK stays in ST_MASK.

A read that coincides with a write is ignored.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, and one cycle after any address-0 write with bit 4 set (start command), the following state is zero: mask, in-service register, rotation offset, poll request, special mask, auto-EOI and rotate flags. Read select points at the request register. The start command also pulses `init_clr` high for exactly one cycle. Reset alone also zeroes the vector base, the nested flag and `rdata`.
- R2: A start command records bit 0 as "mode word needed" and bit 1 as "single", and moves the sequencer to ST_BASE. Address-1 writes then step through ST_CASCADE and ST_MODE as listed above and end in ST_MASK.
- R3: An address-1 write in ST_BASE loads `vec_base` with the data AND 0xF8.
- R4: An address-1 write in ST_MODE sets `spec_nested` from bit 4 and `auto_eoi` from bit 1.
- R5: An address-1 write in ST_MASK loads `mask_o` with the data.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 = 1 arms poll. When bit 1 = 1, bit 0 selects the register for address-0 reads (1 = in-service, 0 = request). When bit 6 = 1, bit 5 becomes the special mask flag.
- R7: An address-0 write with bits 4 and 3 clear carries a command code in bits 7:5. Code 0 clears the rotate-on-auto-EOI flag and code 4 sets it. Code 6 sets the offset to (bits 2:0 + 1) mod 8. Code 2 does nothing.
- R8: Code 1 clears the highest-priority in-service line. Code 5 does the same and then sets the offset to (that line + 1) mod 8. Priority rank is (line − offset) mod 8, and the lowest rank wins. With no line in service, neither code changes anything.
- R9: Code 3 clears in-service line bits 2:0. Code 7 clears that line and also sets the offset to (line + 1) mod 8.
- R10: A read while poll is armed disarms poll. It returns 0x80 OR the winning line, if the best unmasked request ranks strictly above the best in-service line; otherwise it returns 0. Under special mask, masked in-service lines are left out of that comparison. On a win, `poll_ack` pulses with `ack_line`. The line then enters service, unless auto-EOI is on; with auto-EOI on and rotate set, the offset becomes line + 1.
- R11: A read without poll returns the request or in-service register at address 0, as selected, and the mask at address 1. `rdata` updates on the clock edge that samples `rd_en`.
- R12: `level_err` takes bit 3 of each start command, which requests unsupported level-sensitive setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| req_in | input | 8 | Request register from capture logic |
| rdata | output | 8 | Read data, registered |
| mask_o | output | 8 | Mask register |
| isr_o | output | 8 | In-service register |
| vec_base | output | 8 | Vector base, low three bits zero |
| rot_offset | output | 3 | Rotating priority offset |
| rot_on_aeoi | output | 1 | Rotate on auto-EOI flag |
| auto_eoi | output | 1 | Auto-EOI flag |
| spec_nested | output | 1 | Special fully nested flag |
| spec_mask | output | 1 | Special mask flag |
| level_err | output | 1 | Unsupported level-sensitive setup requested |
| poll_ack | output | 1 | One-cycle pulse: poll read acknowledged a line |
| ack_line | output | 3 | Line acknowledged by the last poll |
| init_clr | output | 1 | One-cycle pulse on a start command |

## Verification
The setup sequencer is driven with all four combinations of the single and mode-word flags. Whether the mask lands on the expected write shows which path through ST_CASCADE and ST_MODE was taken.

Poll reads are issued against several request and in-service patterns:
- a lower-numbered request that outranks the in-service line;
- an equal-rank request that must lose;
- an empty request register;
- a masked request;
- special mask hiding an in-service line;
- auto-EOI with rotation.

These cases separate the strict-rank rule from the masking rules. End-of-interrupt commands are applied under a zero and a nonzero offset, and with an empty in-service register, which exposes any search that ignores rotation.

// File: rtl/picd_pkg.sv
package picd_pkg;
    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);
    localparam int DW    = 8;
    localparam int NPF   = 3;
    localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << LW) - 1);

    typedef enum logic [1:0] {
        ST_MASK    = 2'd0,
        ST_BASE    = 2'd1,
        ST_CASCADE = 2'd2,
        ST_MODE    = 2'd3
    } init_step_e;

    localparam logic [2:0] OP_ROT_CLR = 3'd0;
    localparam logic [2:0] OP_NS_EOI  = 3'd1;
    localparam logic [2:0] OP_NOP     = 3'd2;
    localparam logic [2:0] OP_SP_EOI  = 3'd3;
    localparam logic [2:0] OP_ROT_SET = 3'd4;
    localparam logic [2:0] OP_NS_ROT  = 3'd5;
    localparam logic [2:0] OP_SET_PRI = 3'd6;
    localparam logic [2:0] OP_SP_ROT  = 3'd7;
endpackage

// File: rtl/picd_prio_find.sv
module picd_prio_find
    import picd_pkg::*;
(
    input  logic [LINES-1:0] vec,
    input  logic [LW-1:0]    base,
    output logic             hit,
    output logic [LW-1:0]    rank,
    output logic [LW-1:0]    line
);
    logic [2*LINES-1:0] dbl;
    logic [LINES-1:0]   rot;

    always_comb begin
        dbl  = {vec, vec};
        rot  = dbl[base +: LINES];
        hit  = |rot;
        rank = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (rot[i]) rank = LW'(i);
        end
        line = rank + base;
    end
endmodule

// File: rtl/picd_init_seq.sv
module picd_init_seq
    import picd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       need_mode,
    input  logic       single,
    input  logic       wr1,
    output init_step_e step
);
    init_step_e step_q, step_nx;
    logic       need_q, single_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= ST_MASK;
            need_q   <= 1'b0;
            single_q <= 1'b0;
        end else begin
            step_q <= step_nx;
            if (start) begin
                need_q   <= need_mode;
                single_q <= single;
            end
        end
    end

    always_comb begin
        step_nx = step_q;
        if (start) begin
            step_nx = ST_BASE;
        end else if (wr1) begin
            unique case (step_q)
                ST_MASK:    step_nx = ST_MASK;
                ST_BASE:    step_nx = !single_q ? ST_CASCADE : (need_q ? ST_MODE : ST_MASK);
                ST_CASCADE: step_nx = need_q ? ST_MODE : ST_MASK;
                ST_MODE:    step_nx = ST_MASK;
            endcase
        end
    end

    assign step = step_q;
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import picd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] req_in,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] isr_o,
    output logic [DW-1:0] vec_base,
    output logic [LW-1:0] rot_offset,
    output logic          rot_on_aeoi,
    output logic          auto_eoi,
    output logic          spec_nested,
    output logic          spec_mask,
    output logic          level_err,
    output logic          poll_ack,
    output logic [LW-1:0] ack_line,
    output logic          init_clr
);
    localparam int PF_REQ = 0;
    localparam int PF_CUR = 1;
    localparam int PF_EOI = 2;

    logic [DW-1:0] mask_q, isr_q, base_q, rdata_q;
    logic [LW-1:0] off_q, aline_q;
    logic rot_q, aeoi_q, sfnm_q, smm_q, poll_q, rsel_q, lerr_q, pack_q, iclr_q;
    init_step_e step;

    logic             is_init, is_mode, is_cmd, wr1, rd_go, poll_win;
    logic [2:0]       code;
    logic [LW-1:0]    wline;
    logic [LINES-1:0] pf_vec  [NPF];
    logic             pf_hit  [NPF];
    logic [LW-1:0]    pf_rank [NPF];
    logic [LW-1:0]    pf_line [NPF];

    assign is_init = wr_en && !addr && wdata[4];
    assign is_mode = wr_en && !addr && !wdata[4] && wdata[3];
    assign is_cmd  = wr_en && !addr && !wdata[4] && !wdata[3];
    assign wr1     = wr_en && addr;
    assign rd_go   = rd_en && !wr_en;
    assign code    = wdata[DW-1:DW-3];
    assign wline   = wdata[LW-1:0];

    assign pf_vec[PF_REQ] = req_in & ~mask_q;
    assign pf_vec[PF_CUR] = smm_q ? (isr_q & ~mask_q) : isr_q;
    assign pf_vec[PF_EOI] = isr_q;

    for (genvar g = 0; g < NPF; g++) begin : g_pf
        picd_prio_find u_pf (
            .vec  (pf_vec[g]),
            .base (off_q),
            .hit  (pf_hit[g]),
            .rank (pf_rank[g]),
            .line (pf_line[g])
        );
    end

    assign poll_win = pf_hit[PF_REQ] &&
                      (!pf_hit[PF_CUR] || (pf_rank[PF_REQ] < pf_rank[PF_CUR]));

    picd_init_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (is_init),
        .need_mode (wdata[0]),
        .single    (wdata[1]),
        .wr1       (wr1),
        .step      (step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            isr_q   <= '0;
            base_q  <= '0;
            rdata_q <= '0;
            off_q   <= '0;
            aline_q <= '0;
            rot_q   <= 1'b0;
            aeoi_q  <= 1'b0;
            sfnm_q  <= 1'b0;
            smm_q   <= 1'b0;
            poll_q  <= 1'b0;
            rsel_q  <= 1'b0;
            lerr_q  <= 1'b0;
            pack_q  <= 1'b0;
            iclr_q  <= 1'b0;
        end else begin
            pack_q <= 1'b0;
            iclr_q <= 1'b0;
            if (is_init) begin
                mask_q <= '0;
                isr_q  <= '0;
                off_q  <= '0;
                poll_q <= 1'b0;
                smm_q  <= 1'b0;
                aeoi_q <= 1'b0;
                rot_q  <= 1'b0;
                rsel_q <= 1'b0;
                lerr_q <= wdata[3];
                iclr_q <= 1'b1;
            end else if (is_mode) begin
                if (wdata[2]) poll_q <= 1'b1;
                if (wdata[1]) rsel_q <= wdata[0];
                if (wdata[6]) smm_q  <= wdata[5];
            end else if (is_cmd) begin
                case (code)
                    OP_ROT_CLR, OP_ROT_SET: rot_q <= code[2];
                    OP_NS_EOI, OP_NS_ROT: begin
                        if (pf_hit[PF_EOI]) begin
                            isr_q[pf_line[PF_EOI]] <= 1'b0;
                            if (code == OP_NS_ROT) off_q <= pf_line[PF_EOI] + 1'b1;
                        end
                    end
                    OP_SP_EOI: isr_q[wline] <= 1'b0;
                    OP_SET_PRI: off_q <= wline + 1'b1;
                    OP_SP_ROT: begin
                        isr_q[wline] <= 1'b0;
                        off_q        <= wline + 1'b1;
                    end
                    default: ;
                endcase
            end else if (wr1) begin
                unique case (step)
                    ST_MASK:    mask_q <= wdata;
                    ST_BASE:    base_q <= wdata & BASE_KEEP;
                    ST_CASCADE: ;
                    ST_MODE: begin
                        sfnm_q <= wdata[4];
                        aeoi_q <= wdata[1];
                    end
                endcase
            end else if (rd_go) begin
                if (poll_q) begin
                    poll_q <= 1'b0;
                    if (poll_win) begin
                        rdata_q <= 8'h80 | DW'(pf_line[PF_REQ]);
                        pack_q  <= 1'b1;
                        aline_q <= pf_line[PF_REQ];
                        if (aeoi_q) begin
                            if (rot_q) off_q <= pf_line[PF_REQ] + 1'b1;
                        end else begin
                            isr_q[pf_line[PF_REQ]] <= 1'b1;
                        end
                    end else begin
                        rdata_q <= '0;
                    end
                end else begin
                    rdata_q <= addr ? mask_q : (rsel_q ? isr_q : req_in);
                end
            end
        end
    end

    assign rdata       = rdata_q;
    assign mask_o      = mask_q;
    assign isr_o       = isr_q;
    assign vec_base    = base_q;
    assign rot_offset  = off_q;
    assign rot_on_aeoi = rot_q;
    assign auto_eoi    = aeoi_q;
    assign spec_nested = sfnm_q;
    assign spec_mask   = smm_q;
    assign level_err   = lerr_q;
    assign poll_ack    = pack_q;
    assign ack_line    = aline_q;
    assign init_clr    = iclr_q;
endmodule

// File: rtl/picd_chk.sv
module picd_chk
    import picd_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] mask_o,
    input logic [DW-1:0] isr_o,
    input logic [DW-1:0] vec_base,
    input logic [LW-1:0] rot_offset,
    input logic          level_err,
    input logic          poll_ack,
    input logic [LW-1:0] ack_line,
    input logic          init_clr,
    input init_step_e    step
);
    p_init_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=>
            (mask_o == '0 && isr_o == '0 && rot_offset == '0 && init_clr));

    p_base_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && step == ST_BASE) |=>
            (vec_base == {$past(wdata[DW-1:LW]), LW'(0)}));

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && step == ST_MASK) |=> (mask_o == $past(wdata)));

    p_poll_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |-> (rdata[7] && rdata[LW-1:0] == ack_line));

    p_isr_single_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_o & ~$past(isr_o)) <= 1);

    p_level_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (level_err == $past(wdata[3])));
endmodule

bind pic_cmd_decoder picd_chk u_chk (.*);

// File: tb/pic_cmd_decoder_tb.sv
`timescale 1ns/1ps
module pic_cmd_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, req_in = '0;
    logic [7:0] rdata, mask_o, isr_o, vec_base;
    logic [2:0] rot_offset, ack_line;
    logic       rot_on_aeoi, auto_eoi, spec_nested, spec_mask, level_err, poll_ack, init_clr;

    always #2 clk = ~clk;

    pic_cmd_decoder u_dut (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_mask, m_isr, m_base, m_off, m_rot, m_aeoi, m_sfnm, m_smm, m_poll, m_rsel;
    int m_lerr, m_rdata, m_pack, m_aline, m_iclr, m_step, m_need, m_single;

    function automatic int best(input int v, input int off);
        for (int p = 0; p < 8; p++)
            if (((v >> ((p + off) % 8)) & 1) != 0) return p;
        return 8;
    endfunction

    always @(posedge clk) begin
        int code, ln, p, l, rp, cp, cv;
        m_pack = 0;
        m_iclr = 0;
        if (!rst_n) begin
            m_mask = 0; m_isr = 0; m_base = 0; m_off = 0; m_rot = 0; m_aeoi = 0;
            m_sfnm = 0; m_smm = 0; m_poll = 0; m_rsel = 0; m_lerr = 0; m_rdata = 0;
            m_aline = 0; m_step = 0; m_need = 0; m_single = 0;
        end else if (wr_en && !addr && wdata[4]) begin
            m_mask = 0; m_isr = 0; m_off = 0; m_poll = 0; m_smm = 0; m_aeoi = 0;
            m_rot = 0; m_rsel = 0; m_lerr = wdata[3]; m_iclr = 1;
            m_need = wdata[0]; m_single = wdata[1]; m_step = 1;
        end else if (wr_en && !addr && wdata[3]) begin
            if (wdata[2]) m_poll = 1;
            if (wdata[1]) m_rsel = wdata[0];
            if (wdata[6]) m_smm = wdata[5];
        end else if (wr_en && !addr) begin
            code = wdata >> 5;
            ln = wdata & 7;
            case (code)
                0, 4: m_rot = code / 4;
                1, 5: begin
                    p = best(m_isr, m_off);
                    if (p < 8) begin
                        l = (p + m_off) % 8;
                        m_isr &= ~(1 << l);
                        if (code == 5) m_off = (l + 1) % 8;
                    end
                end
                3: m_isr &= ~(1 << ln);
                6: m_off = (ln + 1) % 8;
                7: begin m_isr &= ~(1 << ln); m_off = (ln + 1) % 8; end
                default: ;
            endcase
        end else if (wr_en) begin
            if (m_step == 0) m_mask = wdata;
            else if (m_step == 1) begin
                m_base = wdata & 8'hF8;
                m_step = (m_single == 0) ? 2 : (m_need != 0 ? 3 : 0);
            end else if (m_step == 2) m_step = (m_need != 0) ? 3 : 0;
            else begin
                m_sfnm = wdata[4];
                m_aeoi = wdata[1];
                m_step = 0;
            end
        end else if (rd_en) begin
            if (m_poll != 0) begin
                m_poll = 0;
                rp = best(req_in & ~m_mask & 255, m_off);
                cv = (m_smm != 0) ? (m_isr & ~m_mask & 255) : m_isr;
                cp = best(cv, m_off);
                if (rp < 8 && rp < cp) begin
                    l = (rp + m_off) % 8;
                    m_rdata = 128 | l;
                    m_pack = 1;
                    m_aline = l;
                    if (m_aeoi != 0) begin
                        if (m_rot != 0) m_off = (l + 1) % 8;
                    end else m_isr |= (1 << l);
                end else m_rdata = 0;
            end else m_rdata = addr ? m_mask : (m_rsel != 0 ? m_isr : int'(req_in));
        end
    end

    task automatic chk(input string f, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, f, got, exp, $time);
        end
    endtask

    bit started = 0;
    always @(negedge clk) begin
        if (started && !done) begin
            chk("mask", mask_o, m_mask);
            chk("isr", isr_o, m_isr);
            chk("base", vec_base, m_base);
            chk("offset", rot_offset, m_off);
            chk("rot", rot_on_aeoi, m_rot);
            chk("aeoi", auto_eoi, m_aeoi);
            chk("nested", spec_nested, m_sfnm);
            chk("smask", spec_mask, m_smm);
            chk("lerr", level_err, m_lerr);
            chk("pack", poll_ack, m_pack);
            chk("aline", ack_line, m_aline);
            chk("iclr", init_clr, m_iclr);
            chk("rdata", rdata, m_rdata);
        end
    end

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic poll(input logic [7:0] r);
        req_in = r;
        wr(1'b0, 8'h0C);
        rd(1'b0);
    endtask

    initial begin
        @(posedge clk);
        started = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4: cascaded, mode word needed
        cur_req = "R2"; wr(1'b0, 8'h11);
        cur_req = "R3"; wr(1'b1, 8'h47);
        cur_req = "R2"; wr(1'b1, 8'h04);
        cur_req = "R4"; wr(1'b1, 8'h12);
        cur_req = "R5"; wr(1'b1, 8'hA5); rd(1'b1);
        // single, no mode word
        cur_req = "R2"; wr(1'b0, 8'h12); wr(1'b1, 8'hFF); wr(1'b1, 8'h3C);
        // single, mode word
        wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h5A);
        // cascaded, no mode word
        wr(1'b0, 8'h10); wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'hC3);
        // R12 level request flag
        cur_req = "R12"; wr(1'b0, 8'h18); wr(1'b1, 8'h08); wr(1'b1, 8'h00);
        cur_req = "R1"; wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
        cur_req = "R5"; wr(1'b1, 8'h00);

        // R10 poll cases
        cur_req = "R10";
        poll(8'h24);          // line 2 wins
        poll(8'h24);          // equal rank with in-service: 0
        poll(8'h01);          // line 0 outranks
        poll(8'h00);          // nothing
        wr(1'b1, 8'h02); poll(8'h02); wr(1'b1, 8'h00);  // masked request

        // R11 / R6 plain reads
        cur_req = "R6"; req_in = 8'h93;
        wr(1'b0, 8'h0B);
        cur_req = "R11"; rd(1'b0);
        cur_req = "R6"; wr(1'b0, 8'h0A);
        cur_req = "R11"; rd(1'b0); wr(1'b1, 8'h6E); rd(1'b1); wr(1'b1, 8'h00);

        // R8 nonspecific EOI
        cur_req = "R8"; wr(1'b0, 8'h20); wr(1'b0, 8'hA0);
        // R7 codes
        cur_req = "R7"; wr(1'b0, 8'hC5); wr(1'b0, 8'h80); wr(1'b0, 8'h00); wr(1'b0, 8'h40);
        // rotated priorities with offset 6
        cur_req = "R10"; poll(8'h81); poll(8'h01);
        cur_req = "R6"; wr(1'b0, 8'h68); wr(1'b1, 8'h80);
        cur_req = "R10"; poll(8'h01);
        cur_req = "R6"; wr(1'b0, 8'h48); wr(1'b1, 8'h00);
        // R8 under offset 6: line 7 outranks line 0
        cur_req = "R8"; wr(1'b0, 8'h20); wr(1'b0, 8'h20); wr(1'b0, 8'h20);
        // R9 specific EOI
        cur_req = "R10"; poll(8'h80); poll(8'h01);
        cur_req = "R9"; wr(1'b0, 8'h67); wr(1'b0, 8'hE0); wr(1'b0, 8'h63);

        // R10 auto-EOI with rotate
        cur_req = "R4"; wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h02); wr(1'b1, 8'h00);
        cur_req = "R7"; wr(1'b0, 8'h80);
        cur_req = "R10"; poll(8'h10); poll(8'h10);

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog (run) actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule